// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block sequences a battery-backed byte memory through supply loss and return. It watches four digitized supply-level flags from external comparators and decides when the memory may be written, when its data pins must float, and when the backup cell must feed the array. The comparators and the analog power switch sit outside the block. Only the synchronizing, sequencing and timing logic is here.

A unit leaves the factory with its backup cell unused. The cell is armed the first time the supply climbs past the freshness level, and it stays armed from then on. Whenever the supply falls under the protect threshold, the host's chip and write enables are forced inactive and the data pins are forced to high impedance. Below the switch level the backup cell is selected. When the supply returns above the resume threshold, protection is held for a fixed recovery window before normal access resumes. The window is timed by a counter sized from the clock frequency. A parameter selects one of two threshold grades.

The block has no data stream. Every pin is a plain level-sensitive control or status signal, so no valid/ready handshake or back-pressure applies.

Top module: `pfs_supervisor`

## Requirements
- R1: While reset is asserted and just after reset, the status reads 0 (unarmed), write protect and data float are 1, backup select and armed are 0, and both memory enables are 1 whatever the host drives.
- R2: The first time the synchronized freshness flag (above 4.25 V) is high, the armed output goes to 1, and it stays 1 afterwards through any supply level.
- R3: Until the block is armed, backup select stays 0, even with the switch-level flag low.
- R4: From normal operation, a low protect flag raises write protect and data float and drives both memory enables to 1. The change appears after the third rising clock edge following the flag change, and not after the second.
- R5: With GRADE=0 the protect flag is the 4.5 V comparator and the resume flag is the 4.75 V comparator. With GRADE=1 they are the 4.25 V and 4.5 V comparators.
- R6: Once armed, a low switch-level flag (about 3.0 V) selects the backup source (status 3, backup select 1). A high switch-level flag releases it (status 2, backup select 0).
- R7: A high resume flag in the protected state starts the recovery state (status 4). Protection is held for exactly RECOVER_CYCLES = CLK_KHZ*RECOVER_US/1000 clock cycles, and then normal operation (status 1) begins.
- R8: A low protect flag during recovery returns the block to the protected state. The next recovery then counts a full new window.
- R9: In normal operation, write protect and data float are 0, and both memory enables follow the host enables within the same cycle.
- R10: The status encoding is: 0 unarmed, 1 normal, 2 protected, 3 on backup, 4 recovering.
- R11: In normal operation, a low resume flag with a high protect flag (between the two thresholds) leaves the block in normal operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lvl_300_ok | input | 1 | Supply above the backup switch level (asynchronous) |
| lvl_425_ok | input | 1 | Supply above 4.25 V (asynchronous) |
| lvl_450_ok | input | 1 | Supply above 4.5 V (asynchronous) |
| lvl_475_ok | input | 1 | Supply above 4.75 V (asynchronous) |
| host_ce_n | input | 1 | Chip enable from the host, active low |
| host_we_n | input | 1 | Write enable from the host, active low |
| mem_ce_n | output | 1 | Gated chip enable to the memory, active low |
| mem_we_n | output | 1 | Gated write enable to the memory, active low |
| wr_protect | output | 1 | Write protection in force |
| dq_hiz | output | 1 | Force the memory data pins to high impedance |
| bkp_sel | output | 1 | Select the backup source for the array |
| bkp_armed | output | 1 | Backup source armed (sticky) |
| state_o | output | 3 | Current state code |

## Verification
On every cycle the assertions check the following:
- the arm latch never clears;
- backup select never rises while the block is unarmed, and is high only in the backup state;
- the enables are blocked whenever protection is up, and pass straight through whenever it is down;
- the state code stays legal;
- normal operation is entered only from recovery, after a run of exactly the recovery window.

The three-edge latency from a comparator change and the threshold selection of each grade can only be shown by the bench's scenarios. So can the hysteresis band and the restart of the window after a brownout, because each needs a chosen sequence of flag changes and a count of edges.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  typedef enum logic [2:0] {
    ST_UNARMED    = 3'd0,
    ST_ACTIVE     = 3'd1,
    ST_PROTECTED  = 3'd2,
    ST_ON_BACKUP  = 3'd3,
    ST_RECOVERING = 3'd4
  } pfs_state_e;

  // bit positions of the level flag vector
  localparam int LVL_SW  = 0;
  localparam int LVL_425 = 1;
  localparam int LVL_450 = 2;
  localparam int LVL_475 = 3;
  localparam int LVL_W   = 4;

endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  // reset value 0 means "supply absent", the safe reading
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/pfs_hold_timer.sv
module pfs_hold_timer #(
  parameter int CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);

  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  // counter clears whenever run drops, so each recovery starts a full window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run_i)        cnt <= '0;
    else if (cnt != LAST)   cnt <= cnt + 1'b1;
  end

  assign done_o = run_i && (cnt == LAST);

endmodule

// File: rtl/pfs_fsm.sv
module pfs_fsm
  import pfs_pkg::*;
#(
  parameter int GRADE = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             hold_done_i,
  output pfs_state_e       state_o,
  output logic             armed_o
);

  logic prot_ok, resume_ok, sw_ok, fresh_ok;

  // grade selects which comparators form the protect and resume thresholds
  if (GRADE == 0) begin : g_tight
    assign prot_ok   = lvl_i[LVL_450];
    assign resume_ok = lvl_i[LVL_475];
  end else begin : g_wide
    assign prot_ok   = lvl_i[LVL_425];
    assign resume_ok = lvl_i[LVL_450];
  end

  assign sw_ok    = lvl_i[LVL_SW];
  assign fresh_ok = lvl_i[LVL_425];

  pfs_state_e state_q, state_d;
  logic       armed_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_UNARMED:    if (fresh_ok) state_d = ST_PROTECTED;
      ST_ACTIVE:     if (!prot_ok) state_d = sw_ok ? ST_PROTECTED : ST_ON_BACKUP;
      ST_PROTECTED: begin
        if (!sw_ok)         state_d = ST_ON_BACKUP;
        else if (resume_ok) state_d = ST_RECOVERING;
      end
      ST_ON_BACKUP:  if (sw_ok) state_d = ST_PROTECTED;
      ST_RECOVERING: begin
        if (!prot_ok)         state_d = sw_ok ? ST_PROTECTED : ST_ON_BACKUP;
        else if (hold_done_i) state_d = ST_ACTIVE;
      end
      default:       state_d = ST_UNARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_UNARMED;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (fresh_ok) armed_q <= 1'b1;
    end
  end

  assign state_o = state_q;
  assign armed_o = armed_q;

endmodule

// File: rtl/pfs_supervisor.sv
module pfs_supervisor
  import pfs_pkg::*;
#(
  parameter int GRADE      = 0,
  parameter int CLK_KHZ    = 10000,
  parameter int RECOVER_US = 125000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_300_ok,
  input  logic       lvl_425_ok,
  input  logic       lvl_450_ok,
  input  logic       lvl_475_ok,
  input  logic       host_ce_n,
  input  logic       host_we_n,
  output logic       mem_ce_n,
  output logic       mem_we_n,
  output logic       wr_protect,
  output logic       dq_hiz,
  output logic       bkp_sel,
  output logic       bkp_armed,
  output logic [2:0] state_o
);

  localparam longint RC_RAW = (longint'(CLK_KHZ) * longint'(RECOVER_US)) / 1000;
  localparam int RECOVER_CYCLES = (RC_RAW < 1) ? 1 : int'(RC_RAW);

  logic [LVL_W-1:0] lvl_raw, lvl_s;
  pfs_state_e       st;
  logic             hold_done, armed;

  assign lvl_raw[LVL_SW]  = lvl_300_ok;
  assign lvl_raw[LVL_425] = lvl_425_ok;
  assign lvl_raw[LVL_450] = lvl_450_ok;
  assign lvl_raw[LVL_475] = lvl_475_ok;

  pfs_sync #(.WIDTH(LVL_W), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (lvl_raw),
    .sync_o  (lvl_s)
  );

  pfs_hold_timer #(.CYCLES(RECOVER_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (st == ST_RECOVERING),
    .done_o (hold_done)
  );

  pfs_fsm #(.GRADE(GRADE)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .lvl_i       (lvl_s),
    .hold_done_i (hold_done),
    .state_o     (st),
    .armed_o     (armed)
  );

  logic blocked;
  assign blocked    = (st != ST_ACTIVE);
  assign wr_protect = blocked;
  assign dq_hiz     = blocked;
  assign mem_ce_n   = host_ce_n | blocked;
  assign mem_we_n   = host_we_n | blocked;
  assign bkp_sel    = (st == ST_ON_BACKUP);
  assign bkp_armed  = armed;
  assign state_o    = st;

endmodule

// File: rtl/pfs_supervisor_chk.sv
module pfs_supervisor_chk #(
  parameter int RECOVER_CYCLES = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       host_ce_n,
  input logic       host_we_n,
  input logic       mem_ce_n,
  input logic       mem_we_n,
  input logic       wr_protect,
  input logic       dq_hiz,
  input logic       bkp_sel,
  input logic       bkp_armed,
  input logic [2:0] state_o
);

  logic [31:0] rec_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rec_len <= '0;
    else if (state_o == 3'd4)  rec_len <= rec_len + 1;
    else                       rec_len <= '0;
  end

  // R2
  armed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bkp_armed |=> bkp_armed);

  // R3
  no_backup_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bkp_armed |-> !bkp_sel);

  // R6
  backup_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bkp_sel |-> (state_o == 3'd3));

  // R4
  protect_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_protect |-> (mem_ce_n && mem_we_n && dq_hiz));

  // R9
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_protect |-> (mem_ce_n == host_ce_n && mem_we_n == host_we_n && !dq_hiz));

  // R10
  legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o <= 3'd4) && (wr_protect == (state_o != 3'd1)));

  // R7
  active_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_o == 3'd1) |-> ($past(state_o) == 3'd4 && rec_len == RECOVER_CYCLES));

endmodule

bind pfs_supervisor pfs_supervisor_chk #(.RECOVER_CYCLES(RECOVER_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_ce_n  (host_ce_n),
  .host_we_n  (host_we_n),
  .mem_ce_n   (mem_ce_n),
  .mem_we_n   (mem_we_n),
  .wr_protect (wr_protect),
  .dq_hiz     (dq_hiz),
  .bkp_sel    (bkp_sel),
  .bkp_armed  (bkp_armed),
  .state_o    (state_o)
);

// File: tb/pfs_supervisor_test.sv
module pfs_supervisor_test;

  localparam int CLK_PERIOD = 10;
  localparam int KHZ   = 2000;
  localparam int REC_US = 50;
  localparam int N     = KHZ * REC_US / 1000;   // 100 cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic f300 = 0, f425 = 0, f450 = 0, f475 = 0;
  logic hce = 0, hwe = 0;

  logic ce0, we0, wp0, hz0, bs0, ar0;
  logic [2:0] st0;
  logic ce1, we1, wp1, hz1, bs1, ar1;
  logic [2:0] st1;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfs_supervisor #(.GRADE(0), .CLK_KHZ(KHZ), .RECOVER_US(REC_US)) uut (
    .clk(clk), .rst_n(rst_n),
    .lvl_300_ok(f300), .lvl_425_ok(f425), .lvl_450_ok(f450), .lvl_475_ok(f475),
    .host_ce_n(hce), .host_we_n(hwe),
    .mem_ce_n(ce0), .mem_we_n(we0), .wr_protect(wp0), .dq_hiz(hz0),
    .bkp_sel(bs0), .bkp_armed(ar0), .state_o(st0)
  );

  pfs_supervisor #(.GRADE(1), .CLK_KHZ(KHZ), .RECOVER_US(REC_US)) uut_g1 (
    .clk(clk), .rst_n(rst_n),
    .lvl_300_ok(f300), .lvl_425_ok(f425), .lvl_450_ok(f450), .lvl_475_ok(f475),
    .host_ce_n(hce), .host_we_n(hwe),
    .mem_ce_n(ce1), .mem_we_n(we1), .wr_protect(wp1), .dq_hiz(hz1),
    .bkp_sel(bs1), .bkp_armed(ar1), .state_o(st1)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R1 state", st0, 0);
    check("R1 wr_protect", wp0, 1);
    check("R1 dq_hiz", hz0, 1);
    check("R1 bkp_sel", bs0, 0);
    check("R1 armed", ar0, 0);
    check("R1 ce_n", ce0, 1);
    check("R1 we_n", we0, 1);
  endtask

  task automatic t_unarmed_low;
    tick(10);
    check("R3 bkp_sel unarmed", bs0, 0);
    check("R3 state stays unarmed", st0, 0);
  endtask

  task automatic t_power_up;
    f300 = 1; f425 = 1; f450 = 1;
    tick(3);
    check("R2 armed", ar0, 1);
    check("R10 protected code", st0, 2);
    tick(20);
    check("R5 grade0 waits for 4.75", st0, 2);
    check("R5 grade1 resumes at 4.5", st1, 4);
  endtask

  task automatic t_recover;
    f475 = 1;
    tick(3);
    check("R7 recovering", st0, 4);
    tick(N - 1);
    check("R7 still held", wp0, 1);
    tick(1);
    check("R7 active after window", st0, 1);
    check("R7 protect released", wp0, 0);
  endtask

  task automatic t_pass;
    hce = 1; hwe = 1; #1;
    check("R9 ce_n high", ce0, 1);
    check("R9 we_n high", we0, 1);
    hce = 0; hwe = 1; #1;
    check("R9 ce_n low", ce0, 0);
    check("R9 we_n follows", we0, 1);
    hwe = 0; #1;
    check("R9 we_n low", we0, 0);
    check("R9 dq_hiz", hz0, 0);
    tick(1);
  endtask

  task automatic t_hysteresis;
    f475 = 0;
    tick(10);
    check("R11 stays active", st0, 1);
    check("R11 ce_n passes", ce0, hce);
  endtask

  task automatic t_fail;
    f450 = 0;
    tick(2);
    check("R4 not before third edge", wp0, 0);
    tick(1);
    check("R4 wr_protect", wp0, 1);
    check("R4 dq_hiz", hz0, 1);
    check("R4 ce_n forced", ce0, 1);
    check("R4 we_n forced", we0, 1);
    check("R5 grade1 keeps running", st1, 1);
  endtask

  task automatic t_backup;
    f425 = 0; f300 = 0;
    tick(3);
    check("R6 on backup", st0, 3);
    check("R6 bkp_sel", bs0, 1);
    check("R2 armed kept low supply", ar0, 1);
    f300 = 1;
    tick(3);
    check("R6 released", bs0, 0);
    check("R6 protected", st0, 2);
  endtask

  task automatic t_restart;
    f425 = 1; f450 = 1; f475 = 1;
    tick(3);
    check("R8 recovering", st0, 4);
    tick(50);
    f450 = 0; f475 = 0;
    tick(3);
    check("R8 back to protected", st0, 2);
    f450 = 1; f475 = 1;
    tick(3);
    check("R8 recovering again", st0, 4);
    tick(N - 1);
    check("R8 full new window", st0, 4);
    tick(1);
    check("R8 active", st0, 1);
    check("R2 armed still", ar0, 1);
  endtask

  initial begin
    t_reset();
    t_unarmed_low();
    t_power_up();
    t_recover();
    t_pass();
    t_hysteresis();
    t_fail();
    t_backup();
    t_restart();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule